// File: doc/BRIEF.md
# Preloadable 24-bit Counter Channel

This block is one general-purpose counter channel with a 24-bit count and a small word-wide host register port. The host reaches four word slots through a 2-bit select: the low count word, the high count word, a mode word and a command word. Two preload slots hold values for the counter. A bit in the mode word picks which slot receives a preload write. Preload writes are split across two bus words. The high half is staged first, and the write of the low half commits both halves together.

Reads also span two bus words. A read of the low word returns the low 16 bits of the count and freezes the top 8 bits at the same moment. A following read of the high word returns that frozen value, so the two halves always come from one instant. The counter moves one step for each pulse on an external count-enable input, upward or downward as the mode word chooses. On a downward step from zero it raises a one-cycle terminal-count pulse for an interrupt unit. With auto-reload enabled it also restarts from the second preload slot. Two command bits clear the count or copy the first preload slot into it.

Top module: `pcnt_channel`

## Requirements
- R1: After a synchronous active-low reset the count, both preload slots and the mode word are zero, and `rdata`, `rdata_vld` and `tc_pulse` are low.
- R2: A write to the high slot (select 1) only stages its low 8 data bits. A later write to the low slot (select 0) commits {staged bits, 16 data bits} to the chosen preload slot. A high-slot write alone changes no preload slot.
- R3: Mode bit 2 picks the preload slot for commits: 0 selects slot 0 and 1 selects slot 1. The slot that is not chosen keeps its value.
- R4: A read returns its data in `rdata` with `rdata_vld` high on the cycle after `rd_en`. A low-slot read returns count[15:0] and freezes count[23:16]. A high-slot read returns the frozen byte in bits [7:0] with bits [15:8] zero, even if the count has moved since.
- R5: A command-slot write (select 3) with bit 15 set clears the count to zero. It takes priority over bit 14 and over a count pulse in the same cycle.
- R6: A command-slot write with bit 14 set and bit 15 clear copies preload slot 0 into the count.
- R7: With mode bit 0 clear, each cycle with `cnt_pulse` high adds one to the count. The count wraps from 0xFFFFFF to 0 and gives no terminal-count pulse.
- R8: With mode bit 0 set, a count pulse on a nonzero count subtracts one and gives no terminal-count pulse.
- R9: With mode bit 0 set, a count pulse on a zero count drives `tc_pulse` high for the next cycle. The count then loads preload slot 1 if mode bit 1 (auto-reload) is set, and stays at zero otherwise.
- R10: A mode-slot read (select 2) returns the mode word in bits [2:0] with all other bits zero, whatever was written to those bits.
- R11: Command bits 13:0 have no effect. Without a command and without a count pulse, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Slot select: 0 low word, 1 high word, 2 mode, 3 command |
| wdata | input | 16 | Host write data |
| cnt_pulse | input | 1 | Count-enable pulse, one step per high cycle |
| rdata | output | 16 | Read data, held until the next read |
| rdata_vld | output | 1 | High on the cycle in which `rdata` carries new read data |
| tc_pulse | output | 1 | One-cycle terminal-count event |

## Verification
Every result is due exactly one clock after its cause. Read data and its valid flag follow the read strobe by one edge. A command or count pulse updates the count at the edge that ends its cycle, so the next read sees the new value. The terminal-count pulse is high only in the cycle that follows the zero-crossing pulse. The bench drives inputs on falling edges and samples outputs on the falling edge after the edge under test. Each read pushes its expected word into a queue, and a monitor pops and compares items exactly when `rdata_vld` is high.

// File: rtl/pcnt_pkg.sv
// Package: shared slot selects, command bit positions and mode layout
// for the preloadable counter channel.
package pcnt_pkg;

    // Host slot selects (addr field)
    typedef enum logic [1:0] {
        SLOT_LO   = 2'd0,
        SLOT_HI   = 2'd1,
        SLOT_MODE = 2'd2,
        SLOT_CMD  = 2'd3
    } slot_e;

    // Mode word, bit 0 = down, bit 1 = auto-reload, bit 2 = preload select
    typedef struct packed {
        logic psel;
        logic auto_ld;
        logic down;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int NUM_PR = 2;

endpackage

// File: rtl/pcnt_host_decode.sv
// Module: pcnt_host_decode
// Decodes host writes into the mode register and one-cycle strobes for
// preload staging, preload commit, clear and load-from-slot-0.
// Assumes at most one host write per cycle; clear beats load.
module pcnt_host_decode
    import pcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic [1:0]        cmd_bits,   // [1] = clear, [0] = load
    output mode_t             mode_q,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              cmd_clr,
    output logic              cmd_load
);

    // Holds the mode word written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en && (addr == SLOT_MODE)) begin
            mode_q <= mode_t'(mode_bits);
        end
    end

    // Produces write strobes for the preload halves and commands
    always_comb begin
        wr_lo    = wr_en && (addr == SLOT_LO);
        wr_hi    = wr_en && (addr == SLOT_HI);
        cmd_clr  = wr_en && (addr == SLOT_CMD) && cmd_bits[1];
        cmd_load = wr_en && (addr == SLOT_CMD) && cmd_bits[0] && !cmd_bits[1];
    end

endmodule

// File: rtl/pcnt_preload_bank.sv
// Module: pcnt_preload_bank
// Stages the high half of a preload value and commits it with the low
// half into the slot chosen by psel. Assumes the host writes the high
// half before the low half.
module pcnt_preload_bank
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BUS_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_hi,
    input  logic                          wr_lo,
    input  logic                          psel,
    input  logic [BUS_W-1:0]              wdata,
    output logic [NUM_PR-1:0][CNT_W-1:0]  pr_q
);

    localparam int HI_W = CNT_W - BUS_W;

    logic [HI_W-1:0] stage_q;

    // Captures the staged upper bits on a high-half write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_hi) begin
            stage_q <= wdata[HI_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_PR; g++) begin : g_slot
        logic [CNT_W-1:0] slot_q;

        // Commits the full value into this slot on a low-half write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_lo && (psel == 1'(g))) begin
                slot_q <= {stage_q, wdata};
            end
        end

        assign pr_q[g] = slot_q;
    end

endmodule

// File: rtl/pcnt_core.sv
// Module: pcnt_core
// The counter register and terminal-count event. Priority order:
// clear, load from slot 0, count pulse. A downward step at zero raises
// tc for one cycle and optionally reloads from slot 1.
module pcnt_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_clr,
    input  logic             cmd_load,
    input  logic             cnt_pulse,
    input  logic             down,
    input  logic             auto_ld,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             tc_q
);

    logic [CNT_W-1:0] count_d;
    logic             tc_d;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    // Chooses the next count and terminal-count flag by priority
    always_comb begin
        count_d = count_q;
        tc_d    = 1'b0;
        if (cmd_clr) begin
            count_d = '0;
        end else if (cmd_load) begin
            count_d = load_val;
        end else if (cnt_pulse) begin
            if (!down) begin
                count_d = count_q + CNT_W'(1);
            end else if (at_zero) begin
                tc_d = 1'b1;
                if (auto_ld) begin
                    count_d = reload_val;
                end
            end else begin
                count_d = count_q - CNT_W'(1);
            end
        end
    end

    // Registers the count and terminal-count flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            tc_q    <= 1'b0;
        end else begin
            count_q <= count_d;
            tc_q    <= tc_d;
        end
    end

endmodule

// File: rtl/pcnt_readout.sv
// Module: pcnt_readout
// Registers host read data one cycle after rd_en. A low-word read
// freezes the upper count bits so a later high-word read matches it.
module pcnt_readout
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [CNT_W-1:0]  count,
    input  mode_t             mode,
    output logic [BUS_W-1:0]  rdata,
    output logic              rdata_vld
);

    localparam int HI_W = CNT_W - BUS_W;

    logic [HI_W-1:0] snap_q;

    // Returns the selected word and freezes the upper count bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
            snap_q    <= '0;
        end else begin
            rdata_vld <= rd_en;
            if (rd_en) begin
                unique case (addr)
                    SLOT_LO: begin
                        rdata  <= count[BUS_W-1:0];
                        snap_q <= count[CNT_W-1:BUS_W];
                    end
                    SLOT_HI:   rdata <= {{(BUS_W-HI_W){1'b0}}, snap_q};
                    SLOT_MODE: rdata <= {{(BUS_W-MODE_W){1'b0}}, mode};
                    default:   rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pcnt_channel.sv
// Module: pcnt_channel
// Top of the preloadable counter channel: host decode, preload bank,
// counter core and read path. Assumes the host does not read and write
// in the same cycle and writes the high preload half before the low.
module pcnt_channel
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             cnt_pulse,
    output logic [BUS_W-1:0] rdata,
    output logic             rdata_vld,
    output logic             tc_pulse
);

    mode_t                        mode_q;
    logic                         wr_lo;
    logic                         wr_hi;
    logic                         cmd_clr;
    logic                         cmd_load;
    logic [NUM_PR-1:0][CNT_W-1:0] pr_q;
    logic [CNT_W-1:0]             count_q;

    pcnt_host_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .mode_bits (wdata[MODE_W-1:0]),
        .cmd_bits  (wdata[BUS_W-1:BUS_W-2]),
        .mode_q    (mode_q),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .cmd_clr   (cmd_clr),
        .cmd_load  (cmd_load)
    );

    pcnt_preload_bank #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (wr_hi),
        .wr_lo (wr_lo),
        .psel  (mode_q.psel),
        .wdata (wdata),
        .pr_q  (pr_q)
    );

    pcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_clr    (cmd_clr),
        .cmd_load   (cmd_load),
        .cnt_pulse  (cnt_pulse),
        .down       (mode_q.down),
        .auto_ld    (mode_q.auto_ld),
        .load_val   (pr_q[0]),
        .reload_val (pr_q[1]),
        .count_q    (count_q),
        .tc_q       (tc_pulse)
    );

    pcnt_readout #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (addr),
        .count     (count_q),
        .mode      (mode_q),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

endmodule

// File: rtl/pcnt_channel_chk.sv
// Module: pcnt_channel_chk
// Temporal checks on the counter channel, bound into every instance of
// pcnt_channel. Observes ports plus the count and preload slots.
module pcnt_channel_chk #(
    parameter int CNT_W = 24,
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic             cnt_pulse,
    input logic [BUS_W-1:0] rdata,
    input logic             rdata_vld,
    input logic             tc_pulse,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] pr0,
    input logic             down
);

    localparam int HI_W = CNT_W - BUS_W;

    logic cmd_any;
    assign cmd_any = wr_en && (addr == 2'd3) && (wdata[BUS_W-1] || wdata[BUS_W-2]);

    // R4: every read strobe yields valid data one cycle later
    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rdata_vld);

    // R4: a high-word read never carries bits above the count width
    p_hi_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd1) |=> (rdata[BUS_W-1:HI_W] == '0));

    // R5: clear command zeroes the count
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[BUS_W-1]) |=> (count_q == '0));

    // R6: load command copies slot 0
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[BUS_W-2] && !wdata[BUS_W-1])
        |=> (count_q == $past(pr0)));

    // R7: upward pulse adds one
    p_up_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && !down && !cmd_any) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R9: terminal count only after a downward pulse at zero
    p_tc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(cnt_pulse && down && count_q == '0 && !cmd_any));

    // R11: with no pulse and no command the count holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_pulse && !cmd_any) |=> $stable(count_q));

endmodule

bind pcnt_channel pcnt_channel_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt_pulse (cnt_pulse),
    .rdata     (rdata),
    .rdata_vld (rdata_vld),
    .tc_pulse  (tc_pulse),
    .count_q   (count_q),
    .pr0       (pr_q[0]),
    .down      (mode_q.down)
);

// File: tb/pcnt_channel_tb.sv
// Scoreboard bench for pcnt_channel: read tasks queue expected words,
// a monitor pops them when rdata_vld is seen on a falling edge.
module pcnt_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        cnt_pulse = 1'b0;
    logic [15:0] rdata;
    logic        rdata_vld;
    logic        tc_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcnt_channel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt_pulse (cnt_pulse),
        .rdata     (rdata),
        .rdata_vld (rdata_vld),
        .tc_pulse  (tc_pulse)
    );

    // Compares one value and logs a failure line
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issues a read and queues the expected word
    task automatic host_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // One count pulse, then the terminal-count flag is checked
    task automatic pulse(input logic exp_tc, input string tag);
        @(negedge clk);
        cnt_pulse = 1'b1;
        @(negedge clk);
        cnt_pulse = 1'b0;
        check(tag, {15'd0, tc_pulse}, {15'd0, exp_tc});
    endtask

    // Monitor: pops and compares each returned read word
    always @(negedge clk) begin
        if (rst_n && rdata_vld) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected valid", 16'hFFFF, 16'h0000);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 rdata", rdata, 16'h0000);
        check("R1 rdata_vld", {15'd0, rdata_vld}, 16'h0000);
        check("R1 tc_pulse", {15'd0, tc_pulse}, 16'h0000);
        rst_n = 1'b1;

        host_rd(2'd0, 16'h0000, "R1 count lo");
        host_rd(2'd1, 16'h0000, "R1 count hi");
        host_rd(2'd2, 16'h0000, "R10 mode after reset");

        // Preload slot 0 with 0xABCDEF and load it
        host_wr(2'd1, 16'h00AB);
        host_wr(2'd0, 16'hCDEF);
        host_wr(2'd3, 16'h4000);
        host_rd(2'd0, 16'hCDEF, "R6 loaded lo");
        host_rd(2'd1, 16'h00AB, "R2 loaded hi");

        // High half alone changes nothing
        host_wr(2'd1, 16'h0012);
        host_wr(2'd3, 16'h4000);
        host_rd(2'd0, 16'hCDEF, "R2 hi-only lo");
        host_rd(2'd1, 16'h00AB, "R2 hi-only hi");

        // Select slot 1, down, auto-reload; slot 1 = 3
        host_wr(2'd2, 16'h0007);
        host_rd(2'd2, 16'h0007, "R10 mode readback");
        host_wr(2'd1, 16'h0000);
        host_wr(2'd0, 16'h0003);
        host_wr(2'd3, 16'h4000);
        host_rd(2'd0, 16'hCDEF, "R3 slot0 kept lo");
        host_rd(2'd1, 16'h00AB, "R3 slot0 kept hi");

        // Clear beats load
        host_wr(2'd3, 16'hC000);
        host_rd(2'd0, 16'h0000, "R5 clear lo");
        host_rd(2'd1, 16'h0000, "R5 clear hi");

        // Down at zero with auto-reload
        pulse(1'b1, "R9 tc at zero");
        host_rd(2'd0, 16'h0003, "R9 reload from slot1");
        pulse(1'b0, "R8 no tc when nonzero");
        host_rd(2'd0, 16'h0002, "R8 decrement");

        // Down at zero without auto-reload
        host_wr(2'd2, 16'h0001);
        host_wr(2'd3, 16'h8000);
        pulse(1'b1, "R9 tc no reload");
        host_rd(2'd0, 16'h0000, "R9 stays zero lo");
        host_rd(2'd1, 16'h0000, "R9 stays zero hi");

        // Up count across wrap, with a frozen upper byte
        host_wr(2'd2, 16'h0000);
        host_wr(2'd1, 16'h00FF);
        host_wr(2'd0, 16'hFFFE);
        host_wr(2'd3, 16'h4000);
        host_rd(2'd0, 16'hFFFE, "R4 snapshot lo");
        pulse(1'b0, "R7 up no tc");
        pulse(1'b0, "R7 wrap no tc");
        pulse(1'b0, "R7 after wrap no tc");
        host_rd(2'd1, 16'h00FF, "R4 frozen hi");
        host_rd(2'd0, 16'h0001, "R7 wrapped lo");
        host_rd(2'd1, 16'h0000, "R7 wrapped hi");

        // Command bits other than 15 and 14 do nothing
        host_wr(2'd3, 16'h0123);
        host_rd(2'd0, 16'h0001, "R11 other cmd bits lo");
        host_rd(2'd1, 16'h0000, "R11 other cmd bits hi");

        // Unused mode bits read as zero
        host_wr(2'd2, 16'hFFFF);
        host_rd(2'd2, 16'h0007, "R10 mode upper zero");

        repeat (4) @(negedge clk);
        check("R4 pending reads", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule